// File: doc/BRIEF.md
# Register File Slave on a Two-Wire Management Bus

This block is a bus slave that gives a host on a two-wire serial management bus (SMBus or I2C style) read and write access to a small array of 8-bit control registers. The register array is also driven out as a flat parallel vector, so the rest of the chip always sees the current settings. SCL and SDA come in as raw levels. The block resynchronises them to the system clock and recognises START and STOP. It drives SDA only as an open-drain pull-down enable.

There are four kinds of transfer. Bit 7 of the command byte selects indexed single-byte access (bit 7 = 1) or sequential block access (bit 7 = 0). For single-byte access, bits 6:0 give the register offset. Block transfers always begin at offset 0 and walk upward one register per byte. A block read first reports a length taken from an internal, writable count register. One offset holds a fixed identification value that the host cannot overwrite.

Top module: `smbus_regfile_slave`

## Requirements
- R1: After reset, the identification register (offset 2) reads 0x18 and the count register (offset 3) reads 8. Every other register reads 0x00, and SDA is not driven.
- R2: The slave answers only to 7-bit address 0x69, which means a first byte of 0xD2 for write and 0xD3 for read. A matching address is ACKed. Any other address is NACKed, and every byte that follows is ignored and left unacknowledged until the next START.
- R3: A byte write is address+W, then a command with bit 7 = 1 and the offset in bits 6:0, then one data byte. The data byte, received MSB first, is stored at that offset, and every byte is ACKed.
- R4: A byte read is address+W, then the command, then a repeated START and address+R. The slave returns the register at the commanded offset, MSB first.
- R5: Offset 2 is read-only. A write to it is ACKed and has no effect.
- R6: A block write is address+W, then a command with bit 7 = 0, then a count byte, then data bytes. The data bytes are stored at offsets 0, 1, 2 and upward in order.
- R7: A block read is address+W, then a command with bit 7 = 0, then a repeated START and address+R. The slave returns the value of the count register first. After that it returns registers from offset 0 upward for as long as the host ACKs.
- R8: The count register at offset 3 can be written. Once written, a block read reports the new length.
- R9: An offset at or beyond the number of implemented registers is still ACKed. A write to it is discarded and a read from it returns 0x00.
- R10: A STOP inside a byte ends the transfer. The partial byte is not stored, SDA is released, and the next transfer works normally.
- R11: The slave changes its SDA drive only after SCL falls, or releases it on START or STOP. It never changes the drive while SCL stays high.
- R12: The count byte of a block write is not stored in any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock level from the pad |
| sda_i | input | 1 | Serial data level from the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| regs_o | output | NUM_REGS*8 | Register array, offset k in bits 8k+7:8k |

## Verification
The bench builds the block with NUM_REGS = 6. With that setting, offsets 0x06 and 0x40 are out of range, and so is the tail of a block read at the reset length of 8. The reply of 0x00 for missing registers then shows up in an ordinary block read. A second block read, after the length has been raised to 10, reaches four offsets past the array. The default two synchroniser stages are kept, so the bench's bit timing leaves a margin of several system clocks around every SCL edge.

// File: rtl/smbus_regfile_slave.sv
module smbus_regfile_slave #(
  parameter int          NUM_REGS    = 8,
  parameter logic [6:0]  DEV_ADDR    = 7'h69,
  parameter int          ID_OFFSET   = 2,
  parameter logic [7:0]  ID_VALUE    = 8'h18,
  parameter int          CNT_OFFSET  = 3,
  parameter logic [7:0]  CNT_RESET   = 8'd8,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);

  typedef enum logic [2:0] {IDLE, RX, RX_ACK, TX, TX_ACK} state_t;

  logic [SYNC_STAGES:0] scl_sh, sda_sh;
  logic scl_s, scl_p, sda_s, sda_p;
  logic scl_rise, scl_fall, start_det, stop_det;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-1:0], sda_i};
    end

  assign scl_s = scl_sh[SYNC_STAGES-1];
  assign scl_p = scl_sh[SYNC_STAGES];
  assign sda_s = sda_sh[SYNC_STAGES-1];
  assign sda_p = sda_sh[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

  state_t     state;
  logic [3:0] bitcnt;
  logic [1:0] byte_idx;
  logic [7:0] sh, tx, cmd;
  logic [6:0] ptr;
  logic       ack, go_rd, cnt_first, mack;
  logic [7:0] regs_q [NUM_REGS];
  logic [7:0] rx_byte, rd_val;
  logic       wr_en;

  assign rx_byte = {sh[6:0], sda_s};
  assign wr_en   = (state == RX) && scl_rise && (bitcnt == 4'd7) &&
                   ((byte_idx == 2'd3) || ((byte_idx == 2'd2) && cmd[7]));

  always_comb begin
    rd_val = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (ptr == 7'(i)) rd_val = regs_q[i];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++)
        regs_q[i] <= (i == ID_OFFSET) ? ID_VALUE : (i == CNT_OFFSET) ? CNT_RESET : 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++)
        if (ptr == 7'(i) && i != ID_OFFSET) regs_q[i] <= rx_byte;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= IDLE;
      bitcnt    <= '0;
      byte_idx  <= '0;
      sh        <= '0;
      tx        <= '0;
      cmd       <= '0;
      ptr       <= '0;
      ack       <= 1'b0;
      go_rd     <= 1'b0;
      cnt_first <= 1'b0;
      mack      <= 1'b0;
    end else if (stop_det) begin
      state <= IDLE;
    end else if (start_det) begin
      state    <= RX;
      bitcnt   <= '0;
      byte_idx <= '0;
      go_rd    <= 1'b0;
    end else begin
      case (state)
        RX: begin
          if (scl_rise) begin
            sh     <= rx_byte;
            bitcnt <= bitcnt + 4'd1;
            if (bitcnt == 4'd7) begin
              byte_idx <= (byte_idx == 2'd3) ? byte_idx : byte_idx + 2'd1;
              ack      <= 1'b1;
              if (byte_idx == 2'd0) begin
                ack       <= (rx_byte[7:1] == DEV_ADDR);
                go_rd     <= rx_byte[0];
                cnt_first <= ~cmd[7];
              end else if (byte_idx == 2'd1) begin
                cmd <= rx_byte;
                ptr <= rx_byte[7] ? rx_byte[6:0] : 7'd0;
              end else if (wr_en) begin
                ptr <= ptr + 7'd1;
              end
            end
          end else if (scl_fall && bitcnt == 4'd8) begin
            state <= ack ? RX_ACK : IDLE;
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (go_rd) begin
              state     <= TX;
              tx        <= cnt_first ? regs_q[CNT_OFFSET] : rd_val;
              cnt_first <= 1'b0;
              if (!cnt_first) ptr <= ptr + 7'd1;
            end else begin
              state <= RX;
            end
          end
        end
        TX: begin
          if (scl_rise) bitcnt <= bitcnt + 4'd1;
          else if (scl_fall) begin
            if (bitcnt == 4'd8) state <= TX_ACK;
            else tx <= {tx[6:0], 1'b0};
          end
        end
        TX_ACK: begin
          if (scl_rise) mack <= ~sda_s;
          else if (scl_fall) begin
            if (mack) begin
              state     <= TX;
              bitcnt    <= '0;
              tx        <= cnt_first ? regs_q[CNT_OFFSET] : rd_val;
              cnt_first <= 1'b0;
              if (!cnt_first) ptr <= ptr + 7'd1;
            end else begin
              state <= IDLE;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end

  assign sda_oe_o = (state == RX_ACK) || ((state == TX) && !tx[7]);

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = regs_q[g];
  end

endmodule

module smbus_regfile_slave_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic         scl_rise,
  input logic         scl_fall,
  input logic         start_det,
  input logic         stop_det,
  input logic         sda_oe_o,
  input logic [W-1:0] regs_o
);

  assert_write_on_scl_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> $past(scl_rise));

  assert_drive_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(scl_fall));

  assert_release_timing_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> ($past(scl_fall) || $past(stop_det) || $past(start_det)));

  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe_o);

endmodule

bind smbus_regfile_slave smbus_regfile_slave_chk #(.W(NUM_REGS*8)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
  .start_det(start_det), .stop_det(stop_det), .sda_oe_o(sda_oe_o), .regs_o(regs_o));

// File: tb/smbus_regfile_slave_tb_top.sv
module smbus_regfile_slave_tb_top;
  localparam int NR = 6;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [NR*8-1:0] regs;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  smbus_regfile_slave #(.NUM_REGS(NR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs));

  int checks = 0, fails = 0;
  logic [7:0] model [NR];
  logic cmp_en = 1'b0;
  logic done = 1'b0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] model_vec();
    logic [NR*8-1:0] v;
    for (int i = 0; i < NR; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] model_rd(input int off);
    return (off < NR) ? model[off] : 8'h00;
  endfunction

  // reference comparison on every clock while the bus is idle
  always @(negedge clk)
    if (rst_n && cmp_en) chk("R3 regs_o vs model", 64'(regs), 64'(model_vec()));

  // SDA drive must not change while SCL stays high
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_n && scl_m && prev_scl && sda_oe !== prev_oe)
      chk("R11 sda_oe change with SCL high", 64'(sda_oe), 64'(prev_oe));
    prev_scl <= scl_m;
    prev_oe  <= sda_oe;
  end

  task automatic q();
    repeat (6) @(negedge clk);
  endtask

  task automatic bus_start();
    cmp_en = 1'b0;
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q(); q();
    cmp_en = 1'b1;
  endtask

  task automatic write_bit(input logic b);
    sda_m = b; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic read_bit(output logic b);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); b = sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic send(input logic [7:0] d, output logic ackd);
    logic b;
    for (int i = 7; i >= 0; i--) write_bit(d[i]);
    read_bit(b);
    ackd = ~b;
  endtask

  task automatic recv(output logic [7:0] d, input logic give_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      read_bit(b);
      d[i] = b;
    end
    write_bit(~give_ack);
  endtask

  task automatic wr_byte(input logic [6:0] off, input logic [7:0] d);
    logic a;
    bus_start();
    send(8'hD2, a); chk("R2 address ack", 64'(a), 64'd1);
    send({1'b1, off}, a); chk("R3 command ack", 64'(a), 64'd1);
    send(d, a); chk("R3 data ack", 64'(a), 64'd1);
    if (int'(off) < NR && off != 7'd2) model[off] = d;
    bus_stop();
  endtask

  task automatic rd_byte(input logic [6:0] off, output logic [7:0] d);
    logic a;
    bus_start();
    send(8'hD2, a); chk("R4 address ack", 64'(a), 64'd1);
    send({1'b1, off}, a); chk("R4 command ack", 64'(a), 64'd1);
    bus_start();
    send(8'hD3, a); chk("R4 read address ack", 64'(a), 64'd1);
    recv(d, 1'b0);
    bus_stop();
  endtask

  task automatic blk_rd(input int n, input string req);
    logic a;
    logic [7:0] d;
    bus_start();
    send(8'hD2, a); chk({req, " address ack"}, 64'(a), 64'd1);
    send(8'h00, a); chk({req, " command ack"}, 64'(a), 64'd1);
    bus_start();
    send(8'hD3, a); chk({req, " read address ack"}, 64'(a), 64'd1);
    recv(d, n > 0);
    chk({req, " count byte"}, 64'(d), 64'(model[3]));
    for (int i = 0; i < n; i++) begin
      recv(d, i < n - 1);
      chk({req, " block data"}, 64'(d), 64'(model_rd(i)));
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    for (int i = 0; i < NR; i++) model[i] = 8'h00;
    model[2] = 8'h18;
    model[3] = 8'd8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 reset registers", 64'(regs), 64'(model_vec()));
    chk("R1 reset sda released", 64'(sda_oe), 64'd0);
    cmp_en = 1'b1;

    rd_byte(7'd2, d); chk("R4 read identification", 64'(d), 64'h18);
    rd_byte(7'd3, d); chk("R1 read count default", 64'(d), 64'd8);

    wr_byte(7'd5, 8'hA5);
    rd_byte(7'd5, d); chk("R3 byte write readback", 64'(d), 64'hA5);
    wr_byte(7'd0, 8'h3C);
    rd_byte(7'd0, d); chk("R4 byte read offset 0", 64'(d), 64'h3C);

    wr_byte(7'd2, 8'hFF);
    rd_byte(7'd2, d); chk("R5 read-only unchanged", 64'(d), 64'h18);

    // foreign address: NACK and ignore
    bus_start();
    send(8'hA4, a); chk("R2 foreign address nack", 64'(a), 64'd0);
    send(8'h85, a); chk("R2 ignored byte nack", 64'(a), 64'd0);
    send(8'h11, a); chk("R2 ignored data nack", 64'(a), 64'd0);
    bus_stop();
    rd_byte(7'd5, d); chk("R2 register untouched", 64'(d), 64'hA5);

    // block write, count byte 3, three data bytes
    bus_start();
    send(8'hD2, a); chk("R6 address ack", 64'(a), 64'd1);
    send(8'h00, a); chk("R6 command ack", 64'(a), 64'd1);
    send(8'h03, a); chk("R12 count byte ack", 64'(a), 64'd1);
    send(8'h11, a); chk("R6 data0 ack", 64'(a), 64'd1);
    send(8'h22, a); chk("R6 data1 ack", 64'(a), 64'd1);
    send(8'h33, a); chk("R5 data2 ack", 64'(a), 64'd1);
    model[0] = 8'h11;
    model[1] = 8'h22;
    bus_stop();
    rd_byte(7'd3, d); chk("R12 count byte not stored", 64'(d), 64'd8);
    rd_byte(7'd1, d); chk("R6 block write offset 1", 64'(d), 64'h22);

    blk_rd(8, "R7");

    wr_byte(7'd3, 8'd10);
    blk_rd(10, "R8");

    wr_byte(7'h40, 8'h5A);
    rd_byte(7'h40, d); chk("R9 out of range read", 64'(d), 64'h00);
    rd_byte(7'd6, d); chk("R9 first missing offset", 64'(d), 64'h00);

    // STOP in the middle of a data byte
    bus_start();
    send(8'hD2, a); chk("R10 address ack", 64'(a), 64'd1);
    send(8'h85, a); chk("R10 command ack", 64'(a), 64'd1);
    for (int i = 0; i < 4; i++) write_bit(1'b0);
    bus_stop();
    chk("R10 sda released", 64'(sda_oe), 64'd0);
    rd_byte(7'd5, d); chk("R10 partial byte discarded", 64'(d), 64'hA5);
    wr_byte(7'd4, 8'h96);
    rd_byte(7'd4, d); chk("R10 next transfer works", 64'(d), 64'h96);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule